// File: doc/BRIEF.md
# Geographic Configuration Space Decoder

This block serves the configuration space of a backplane slave card: a read-only configuration ROM, a small set of standard control/status registers and two default user registers that hold the interrupt level and interrupt vector. The slot's 512 kB page in the 24-bit address space comes from the five geographic address lines on the backplane. A parity line qualifies them. A card whose geography is missing or corrupt cannot be reached in this space at all.

A requester presents one access at a time as a word address, an address modifier, write data, four byte-lane enables and a write flag. The block answers one clock later with an acknowledge and read data. Within the page only the last byte of every 32-bit word holds data. The other three byte lanes read as zero and ignore writes. The module-reset control bit is not stored. Setting it gives a one-cycle reset pulse to the rest of the card.

Top module: `cfg_space_decoder`

## Requirements
- R1: An access is served only when its address modifier is 0x2F. Any other modifier gets no acknowledge and changes no state.
- R2: An access is served only when address bits 23..19 equal the registered geographic base. An access to another page gets no acknowledge.
- R3: The five geographic bits together with the parity bit must hold an odd number of ones. If they do not, the base is 0 and no access is acknowledged. A geographic value of 0 is also treated as invalid.
- R4: When all five geographic lines read 1, the base is 0 and no access is acknowledged.
- R5: Byte lane k (req_be[k]) is the byte at word offset k. Its data is carried on bits [31-8k -: 8], so lane 3 is bits [7:0]. Only lane 3 is live. Read data bits [31:8] are always 0. A read without req_be[3] returns 0. A write without req_be[3] changes nothing.
- R6: Word indices 0 to 1023 (byte offsets 0x00003 to 0x00FFF) read the configuration ROM. Word index i returns i[7:0] XOR ROM_SEED, except word 7, which returns 0x43, and word 8, which returns 0x52.
- R7: The word at byte offset 0x7FFFF reads the base in bits 7..3 and cannot be written. Module-enable is bit 4. Writing 1 to bit 4 at 0x7FFFB sets it, and writing 1 to bit 4 at 0x7FFF7 clears it. Both of these words read the current status. Module-enable resets to 0.
- R8: The interrupt vector lives at 0x7FF5F and the interrupt level at 0x7FF5B. Both are 8-bit read/write registers that reset to 0x00 and drive irq_vector and irq_level.
- R9: Writing 1 to bit 7 at 0x7FFFB raises mod_reset for exactly one cycle, in the cycle of the acknowledge. The bit is never stored and always reads 0.
- R10: Any other offset in the page reads 0 and is still acknowledged. Writes to such offsets have no effect.
- R11: An accepted access raises rsp_ack for exactly one cycle, the cycle after the request. A write returns 0 as read data. After reset, rsp_ack, mod_reset, irq_level and irq_vector are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| geo_addr | input | 5 | Geographic slot address, already synchronised |
| geo_par | input | 1 | Geographic parity line |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 22 | Word address (address bits 23..2) |
| req_am | input | 6 | Address modifier |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane enables |
| req_we | input | 1 | 1 = write, 0 = read |
| rsp_ack | output | 1 | Access acknowledged |
| rsp_rdata | output | 32 | Read data, valid with rsp_ack |
| mod_reset | output | 1 | One-cycle module reset pulse |
| irq_level | output | 8 | Interrupt level register |
| irq_vector | output | 8 | Interrupt vector register |

## Verification
The assertions check these properties on every cycle:
- every acknowledge follows a request with the configuration modifier and the matching page;
- the upper byte lanes stay zero;
- the base never validates on bad parity or all-ones geography;
- the reset pulse never lasts two cycles;
- the user registers only change after a write.

Only the bench scenarios can show that the data values are right. These cover the ROM contents, the set/clear behaviour of module-enable, reads that return zero at unused offsets, and the lockout after the geography changes.

// File: rtl/cfg_space_pkg.sv
// Package: constants shared by the configuration-space decoder.
// Assumes word addressing (byte address bits 23..2).
package cfg_space_pkg;
    localparam logic [5:0]  CFG_AM      = 6'h2F;
    localparam int          PAGE_LO_BIT = 19;          // byte address bit of page base
    localparam logic [16:0] W_BAR       = 17'h1FFFF;   // byte 0x7FFFF
    localparam logic [16:0] W_BITSET    = 17'h1FFFE;   // byte 0x7FFFB
    localparam logic [16:0] W_BITCLR    = 17'h1FFFD;   // byte 0x7FFF7
    localparam logic [16:0] W_IRQ_VEC   = 17'h1FFD7;   // byte 0x7FF5F
    localparam logic [16:0] W_IRQ_LVL   = 17'h1FFD6;   // byte 0x7FF5B
    localparam int          BIT_ENABLE  = 4;
    localparam int          BIT_RESET   = 7;
endpackage

// File: rtl/cfg_geo_base.sv
// Geographic base register: checks the geographic lines and registers the page base.
// The base is valid only with odd parity over geo+parity, not all ones and not zero.
// Assumes the geographic lines are already synchronised to clk.
module cfg_geo_base #(
    parameter int GEO_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GEO_W-1:0] geo_addr,
    input  logic             geo_par,
    output logic [GEO_W-1:0] base,
    output logic             base_ok
);
    localparam logic [GEO_W-1:0] ALL_ONES = '1;

    logic geo_good;

    // Qualify the geography: odd parity, slot lines present, non-zero slot
    always_comb begin
        geo_good = (^{geo_addr, geo_par}) && (geo_addr != ALL_ONES) && (geo_addr != '0);
    end

    // Register the base, forcing it to zero on a faulty geography
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base    <= '0;
            base_ok <= 1'b0;
        end else begin
            base    <= geo_good ? geo_addr : '0;
            base_ok <= geo_good;
        end
    end

    AST_PARITY_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(base_ok) |-> $past(^{geo_addr, geo_par})) else $error("parity"); // R3
    AST_NO_BASE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        base_ok |-> base != ALL_ONES) else $error("all ones"); // R4
    AST_OK_NONZERO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        base_ok |-> base != '0) else $error("zero base"); // R3
endmodule

// File: rtl/cfg_rom.sv
// Configuration ROM: combinational byte lookup, content computed from the word index.
// Word 7 and word 8 hold the two marker characters; everything else follows the seed.
module cfg_rom #(
    parameter int         ROM_WORDS = 1024,
    parameter logic [7:0] ROM_SEED  = 8'hA5,
    localparam int        IDX_W     = $clog2(ROM_WORDS)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       data
);
    // Compute the byte held at a word index
    always_comb begin
        if (idx == IDX_W'(7))      data = 8'h43;
        else if (idx == IDX_W'(8)) data = 8'h52;
        else                       data = idx[7:0] ^ ROM_SEED;
    end
endmodule

// File: rtl/cfg_csr_bank.sv
// Control/status registers and default user registers of the configuration page.
// Only the live byte (lane 3) is presented here. The reset bit produces a pulse and is never stored.
module cfg_csr_bank
    import cfg_space_pkg::*;
#(
    parameter int GEO_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [16:0]      word,
    input  logic [7:0]       wbyte,
    input  logic [GEO_W-1:0] base,
    output logic [7:0]       rbyte,
    output logic             mod_reset,
    output logic [7:0]       irq_level,
    output logic [7:0]       irq_vector
);
    logic enable_q;

    // Write path for enable, the user registers and the reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q   <= 1'b0;
            irq_level  <= '0;
            irq_vector <= '0;
            mod_reset  <= 1'b0;
        end else begin
            mod_reset <= wr_en && (word == W_BITSET) && wbyte[BIT_RESET];
            if (wr_en && word == W_BITSET && wbyte[BIT_ENABLE]) enable_q <= 1'b1;
            else if (wr_en && word == W_BITCLR && wbyte[BIT_ENABLE]) enable_q <= 1'b0;
            if (wr_en && word == W_IRQ_LVL) irq_level  <= wbyte;
            if (wr_en && word == W_IRQ_VEC) irq_vector <= wbyte;
        end
    end

    // Read mux for the register words; unknown words return zero
    always_comb begin
        rbyte = '0;
        case (word)
            W_BAR:               rbyte = 8'({base, 3'b000});
            W_BITSET, W_BITCLR:  rbyte = 8'(enable_q) << BIT_ENABLE;
            W_IRQ_LVL:           rbyte = irq_level;
            W_IRQ_VEC:           rbyte = irq_vector;
            default:             rbyte = '0;
        endcase
    end

    AST_RESET_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mod_reset |=> !mod_reset) else $error("reset pulse"); // R9
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(irq_level) && $stable(irq_vector)) else $error("user reg"); // R8
endmodule

// File: rtl/cfg_space_decoder.sv
// Top: matches configuration-space accesses against the geographic page, selects
// the ROM or the register bank, and registers the acknowledge and read data.
// Assumes one request per cycle at most, with the inputs stable at the clock edge.
module cfg_space_decoder
    import cfg_space_pkg::*;
#(
    parameter int         GEO_W     = 5,
    parameter int         DATA_W    = 32,
    parameter int         ROM_WORDS = 1024,
    parameter logic [7:0] ROM_SEED  = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GEO_W-1:0]  geo_addr,
    input  logic              geo_par,
    input  logic              req_valid,
    input  logic [21:0]       req_addr,
    input  logic [5:0]        req_am,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [3:0]        req_be,
    input  logic              req_we,
    output logic              rsp_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mod_reset,
    output logic [7:0]        irq_level,
    output logic [7:0]        irq_vector
);
    localparam int IDX_W    = $clog2(ROM_WORDS);
    localparam int PAGE_TOP = 21;
    localparam int PAGE_BOT = PAGE_LO_BIT - 2;

    logic [GEO_W-1:0] base;
    logic             base_ok;
    logic             hit;
    logic [16:0]      word;
    logic             rom_sel;
    logic [7:0]       rom_byte;
    logic [7:0]       csr_byte;
    logic [7:0]       live_byte;

    cfg_geo_base #(.GEO_W(GEO_W)) u_geo (
        .clk(clk), .rst_n(rst_n), .geo_addr(geo_addr), .geo_par(geo_par),
        .base(base), .base_ok(base_ok)
    );

    // Decode page, modifier and region of the current request
    always_comb begin
        word    = req_addr[PAGE_BOT-1:0];
        hit     = req_valid && base_ok && (req_am == CFG_AM)
                  && (req_addr[PAGE_TOP:PAGE_BOT] == base);
        rom_sel = (word < 17'(ROM_WORDS));
    end

    cfg_rom #(.ROM_WORDS(ROM_WORDS), .ROM_SEED(ROM_SEED)) u_rom (
        .idx(word[IDX_W-1:0]), .data(rom_byte)
    );

    cfg_csr_bank #(.GEO_W(GEO_W)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(hit && req_we && req_be[3]),
        .word(word), .wbyte(req_wdata[7:0]), .base(base),
        .rbyte(csr_byte), .mod_reset(mod_reset),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    // Pick the live lane content for a read
    always_comb begin
        live_byte = rom_sel ? rom_byte : csr_byte;
    end

    // Register the response: one-cycle acknowledge, only lane 3 carries data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ack   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ack   <= hit;
            rsp_rdata <= (hit && !req_we && req_be[3]) ? DATA_W'(live_byte) : '0;
        end
    end

    AST_ACK_NEEDS_CFG_AM: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |-> $past(req_am) == CFG_AM) else $error("am"); // R1
    AST_ACK_NEEDS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |-> $past(req_addr[PAGE_TOP:PAGE_BOT]) == $past(base) && $past(base_ok)) else $error("page"); // R2
    AST_UPPER_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[DATA_W-1:8] == '0) else $error("lanes"); // R5
    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |-> $past(req_valid)) else $error("ack"); // R11
endmodule

// File: tb/test_cfg_space_decoder.sv
// Bench: directed corner cases plus seeded random accesses checked against a model.
module test_cfg_space_decoder;
    localparam logic [7:0] SEED_B = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  geo_addr = 5'd6;
    logic        geo_par = 1'b0;
    logic        req_valid = 1'b0;
    logic [21:0] req_addr = '0;
    logic [5:0]  req_am = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_we = 1'b0;
    logic        rsp_ack, mod_reset;
    logic [31:0] rsp_rdata;
    logic [7:0]  irq_level, irq_vector;

    int n_chk = 0, n_fail = 0;
    logic       m_en;
    logic [7:0] m_lvl, m_vec;
    logic [4:0] m_base;
    logic       m_ok;

    always #4 clk = ~clk;

    cfg_space_decoder i_cfg_space_decoder (
        .clk(clk), .rst_n(rst_n), .geo_addr(geo_addr), .geo_par(geo_par),
        .req_valid(req_valid), .req_addr(req_addr), .req_am(req_am),
        .req_wdata(req_wdata), .req_be(req_be), .req_we(req_we),
        .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .mod_reset(mod_reset),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [16:0] w);
        if (w < 17'd1024) begin
            if (w == 17'd7) return 8'h43;
            if (w == 17'd8) return 8'h52;
            return w[7:0] ^ SEED_B;
        end
        case (w)
            17'h1FFFF: return {m_base, 3'b000};
            17'h1FFFE, 17'h1FFFD: return {3'b000, m_en, 4'b0000};
            17'h1FFD6: return m_lvl;
            17'h1FFD7: return m_vec;
            default:   return 8'h00;
        endcase
    endfunction

    // Sets geography and updates the model's base after it has been registered
    task automatic set_geo(input logic [4:0] g, input logic p);
        @(negedge clk);
        geo_addr = g; geo_par = p;
        m_ok   = (^{g, p}) && g != 5'h1F && g != 5'h00;
        m_base = m_ok ? g : 5'h00;
        @(negedge clk); @(negedge clk);
    endtask

    // One access: drive at negedge, sample the registered response at the next negedge
    task automatic access(input string req, input logic [4:0] page, input logic [16:0] w,
                          input logic [5:0] am, input logic we, input logic [3:0] be,
                          input logic [31:0] wd);
        logic hit, exp_rst;
        logic [7:0] rd;
        hit = m_ok && am == 6'h2F && page == m_base;
        rd  = exp_byte(w);
        req_valid = 1'b1; req_addr = {page, w}; req_am = am;
        req_we = we; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        exp_rst = hit && we && be[3] && w == 17'h1FFFE && wd[7];
        check({req, " ack"}, 32'(rsp_ack), 32'(hit));
        check({req, " rdata"}, rsp_rdata, (hit && !we && be[3]) ? 32'(rd) : 32'h0);
        check({req, " R9 pulse"}, 32'(mod_reset), 32'(exp_rst));
        if (hit && we && be[3]) begin
            if (w == 17'h1FFFE && wd[4]) m_en = 1'b1;
            else if (w == 17'h1FFFD && wd[4]) m_en = 1'b0;
            if (w == 17'h1FFD6) m_lvl = wd[7:0];
            if (w == 17'h1FFD7) m_vec = wd[7:0];
        end
        @(negedge clk);
        check({req, " R9 one cycle"}, 32'(mod_reset), 32'h0);
        check({req, " R8 level"}, 32'(irq_level), 32'(m_lvl));
        check({req, " R8 vector"}, 32'(irq_vector), 32'(m_vec));
    endtask

    initial begin
        int seed;
        logic [16:0] picks [0:9];
        picks[0] = 17'h00000; picks[1] = 17'h00007; picks[2] = 17'h00008;
        picks[3] = 17'h003FF; picks[4] = 17'h1FFFF; picks[5] = 17'h1FFFE;
        picks[6] = 17'h1FFFD; picks[7] = 17'h1FFD7; picks[8] = 17'h1FFD6;
        picks[9] = 17'h00400;
        m_en = 0; m_lvl = 0; m_vec = 0; m_base = 0; m_ok = 0;
        seed = 32'h1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R11 reset ack", 32'(rsp_ack), 32'h0);
        check("R11 reset pulse", 32'(mod_reset), 32'h0);
        check("R11 reset level", 32'(irq_level), 32'h0);
        rst_n = 1'b1;
        // geo 6 = 00110: two ones, parity 1 gives odd
        set_geo(5'd6, 1'b1);
        access("R6 rom word0", 5'd6, 17'h0, 6'h2F, 0, 4'hF, 0);
        access("R6 rom C", 5'd6, 17'h7, 6'h2F, 0, 4'h8, 0);
        access("R6 rom R", 5'd6, 17'h8, 6'h2F, 0, 4'h8, 0);
        access("R6 rom last", 5'd6, 17'h3FF, 6'h2F, 0, 4'h8, 0);
        access("R7 bar", 5'd6, 17'h1FFFF, 6'h2F, 0, 4'h8, 0);
        access("R7 bar ro", 5'd6, 17'h1FFFF, 6'h2F, 1, 4'h8, 32'hFF);
        access("R7 bar reread", 5'd6, 17'h1FFFF, 6'h2F, 0, 4'h8, 0);
        access("R7 set enable", 5'd6, 17'h1FFFE, 6'h2F, 1, 4'h8, 32'h10);
        access("R7 read enable", 5'd6, 17'h1FFFD, 6'h2F, 0, 4'h8, 0);
        access("R9 reset pulse", 5'd6, 17'h1FFFE, 6'h2F, 1, 4'h8, 32'h80);
        access("R9 reset not stored", 5'd6, 17'h1FFFE, 6'h2F, 0, 4'h8, 0);
        access("R7 clear enable", 5'd6, 17'h1FFFD, 6'h2F, 1, 4'h8, 32'h10);
        access("R8 level write", 5'd6, 17'h1FFD6, 6'h2F, 1, 4'h8, 32'h03);
        access("R8 vector write", 5'd6, 17'h1FFD7, 6'h2F, 1, 4'h8, 32'h5C);
        access("R5 lane write ignored", 5'd6, 17'h1FFD6, 6'h2F, 1, 4'h7, 32'hFFFFFF07);
        access("R5 lane read zero", 5'd6, 17'h1FFD6, 6'h2F, 0, 4'h7, 0);
        access("R10 unimpl", 5'd6, 17'h10000, 6'h2F, 0, 4'h8, 0);
        access("R10 unimpl write", 5'd6, 17'h10000, 6'h2F, 1, 4'h8, 32'h77);
        access("R1 wrong am", 5'd6, 17'h1FFD6, 6'h39, 1, 4'h8, 32'h44);
        access("R2 wrong page", 5'd7, 17'h1FFD6, 6'h2F, 1, 4'h8, 32'h44);
        set_geo(5'd6, 1'b0);   // even parity
        access("R3 bad parity", 5'd6, 17'h1FFFF, 6'h2F, 0, 4'h8, 0);
        access("R3 bad parity page0", 5'd0, 17'h1FFFF, 6'h2F, 0, 4'h8, 0);
        set_geo(5'h1F, 1'b0);  // no geography, parity happens to be odd
        access("R4 all ones", 5'h1F, 17'h1FFFF, 6'h2F, 0, 4'h8, 0);
        access("R4 all ones page0", 5'd0, 17'h0, 6'h2F, 0, 4'h8, 0);
        set_geo(5'd9, 1'b1);   // 01001 + 1 = three ones
        for (int k = 0; k < 300; k++) begin
            logic [4:0]  pg;
            logic [16:0] w;
            logic [5:0]  am;
            pg = ($urandom % 5 == 0) ? 5'($urandom) : 5'd9;
            am = ($urandom % 5 == 0) ? 6'($urandom) : 6'h2F;
            w  = ($urandom % 4 == 0) ? 17'($urandom) : picks[$urandom % 10];
            access("R5 R6 R7 R8 R10 random", pg, w, am, 1'($urandom),
                   4'($urandom), $urandom);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule